// File: doc/BRIEF.md
# Keyed Index/Data Configuration Port

This block gives software access to a bank of configuration registers through only two byte addresses on a simple byte-wide bus. One address carries a register number (the index port) and the other carries the contents of that register (the data port). Out of reset the port is locked: reads of either address return 0xFF, and writes to the data address have no effect. Software opens the port by writing a fixed four-byte key to the index address. It leaves by writing a close value through a dedicated register.

Once open, software selects a register number on the index port and then moves bytes through the data port. A small group of global registers is always reachable: a logical-device selector and three read-only identity bytes. Registers from 0x30 upward are banked. The selector picks which device's copy of them the data port reaches. Each device bank provides an enable byte, a two-byte base address and a few general bytes. The bank storage is a single synchronous memory.

Top module: `kcp_cfg_port`

## Requirements
- R1: After reset the port is locked, the held index and the device selector are 0x00, and the read data output is 0xFF.
- R2: The index port is the bus address 0x2E and the data port is 0x2F. Writing the bytes 0x87, 0x01, 0x55, 0x55 to the index port, in that order, opens the port after the last byte.
- R3: A byte in the key that does not match the expected one restarts matching. If that byte is 0x87, it is taken as the first key byte of a new attempt.
- R4: While the port is locked, reads of the index or data port return 0xFF. Data-port writes change no register.
- R5: While the port is open, a write to the index port stores the register number, and a read of the index port returns it.
- R6: Through the data port, index 0x20 reads the identity high byte (0x87 by default) and index 0x21 reads the low byte (0x12). Index 0x22 reads the revision in bits 3:0 (8 by default) with bits 7:4 zero. Writes to these three indices are ignored.
- R7: Index 0x07 holds the logical device number, which can be read and written. It selects which device bank the indices from 0x30 upward reach. The banks are independent of each other.
- R8: Each of the NUM_LDN banks returns what was last written to its own index 0x30 (enable), 0x60 (base high), 0x61 (base low) and 0x70 up to 0x74 (general bytes, 2**SLOT_W-3 of them).
- R9: An index without storage reads as 0x00 and ignores writes. This also applies to every banked index while the selector is at or above NUM_LDN.
- R10: Writing 0x02 to the data port while the index is 0x02 locks the port again. Any other value written there leaves the port open.
- R11: Read data appears on the output in the cycle after the read strobe. It holds until the next read of the index or data port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the current access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the cycle after bus_rd |

## Verification
The bench builds the block with its default parameters: four device banks with eight slots each, identity 0x8712 and revision 8. With four banks, the bench can fill every bank with distinct values and read them all back. It can also set the selector to 5, which lies above the last bank, to confirm that banked writes are dropped and banked reads return zero. The five general slots allow the bench to probe both the last implemented index (0x74) and the first unimplemented one (0x75).

// File: rtl/kcp_pkg.sv
package kcp_pkg;
  localparam int KEY_LEN = 4;
  localparam logic [7:0] KEY_SEQ [KEY_LEN] = '{8'h87, 8'h01, 8'h55, 8'h55};

  localparam logic [7:0] IDX_CLOSE   = 8'h02;
  localparam logic [7:0] CLOSE_VAL   = 8'h02;
  localparam logic [7:0] IDX_LDN     = 8'h07;
  localparam logic [7:0] IDX_ID_HI   = 8'h20;
  localparam logic [7:0] IDX_ID_LO   = 8'h21;
  localparam logic [7:0] IDX_REV     = 8'h22;
  localparam logic [7:0] IDX_ENABLE  = 8'h30;
  localparam logic [7:0] IDX_BASE_HI = 8'h60;
  localparam logic [7:0] IDX_BASE_LO = 8'h61;
  localparam logic [7:0] IDX_GEN0    = 8'h70;
endpackage

// File: rtl/kcp_key_unlock.sv
module kcp_key_unlock
  import kcp_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       key_wr,
  input  logic [7:0] key_byte,
  input  logic       relock,
  output logic       unlocked
);
  localparam int CNT_W = (KEY_LEN > 1) ? $clog2(KEY_LEN) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(KEY_LEN - 1);

  logic [CNT_W-1:0] match_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      match_cnt <= '0;
      unlocked  <= 1'b0;
    end else if (relock) begin
      match_cnt <= '0;
      unlocked  <= 1'b0;
    end else if (key_wr && !unlocked) begin
      if (key_byte == KEY_SEQ[match_cnt]) begin
        if (match_cnt == LAST) begin
          match_cnt <= '0;
          unlocked  <= 1'b1;
        end else begin
          match_cnt <= match_cnt + CNT_W'(1);
        end
      end else if (key_byte == KEY_SEQ[0]) begin
        match_cnt <= CNT_W'(1);
      end else begin
        match_cnt <= '0;
      end
    end
  end

  // R2: opening only follows the final key byte at the final position
  p_open_on_last_key_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(unlocked) |-> ($past(key_wr) && $past(key_byte) == KEY_SEQ[KEY_LEN-1]
                         && $past(match_cnt) == LAST));

  // R10: a close request always locks
  p_close_locks_r10: assert property (@(posedge clk) disable iff (rst)
    relock |=> !unlocked);

  // R3: without an index write the locked state cannot change
  p_no_open_without_write_r3: assert property (@(posedge clk) disable iff (rst)
    (!unlocked && !key_wr) |=> !unlocked);
endmodule

// File: rtl/kcp_bank_decode.sv
module kcp_bank_decode
  import kcp_pkg::*;
#(
  parameter int NUM_LDN = 4,
  parameter int SLOT_W  = 3,
  localparam int LDN_W  = $clog2(NUM_LDN),
  localparam int AW     = LDN_W + SLOT_W
)(
  input  logic [7:0]    index,
  input  logic [7:0]    ldn,
  output logic          hit,
  output logic [AW-1:0] ram_addr
);
  localparam int GEN_REGS = (1 << SLOT_W) - 3;

  logic             slot_hit;
  logic [SLOT_W-1:0] slot;

  always_comb begin
    slot_hit = 1'b0;
    slot     = '0;
    if (index == IDX_ENABLE) begin
      slot_hit = 1'b1;
      slot     = SLOT_W'(0);
    end else if (index == IDX_BASE_HI) begin
      slot_hit = 1'b1;
      slot     = SLOT_W'(1);
    end else if (index == IDX_BASE_LO) begin
      slot_hit = 1'b1;
      slot     = SLOT_W'(2);
    end else if (index >= IDX_GEN0 && int'(index) < int'(IDX_GEN0) + GEN_REGS) begin
      slot_hit = 1'b1;
      slot     = SLOT_W'(index - IDX_GEN0 + 8'd3);
    end
  end

  assign hit      = slot_hit && (int'(ldn) < NUM_LDN);
  assign ram_addr = {ldn[LDN_W-1:0], slot};
endmodule

// File: rtl/kcp_bank_ram.sv
module kcp_bank_ram #(
  parameter int AW = 5
)(
  input  logic          clk,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata
);
  localparam int DEPTH = 1 << AW;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    if (re) rdata <= mem[addr];
  end
endmodule

// File: rtl/kcp_cfg_port.sv
module kcp_cfg_port
  import kcp_pkg::*;
#(
  parameter int          ADDR_W     = 16,
  parameter logic [15:0] INDEX_ADDR = 16'h002E,
  parameter logic [15:0] DATA_ADDR  = 16'h002F,
  parameter logic [15:0] CHIP_ID    = 16'h8712,
  parameter logic [3:0]  CHIP_REV   = 4'h8,
  parameter int          NUM_LDN    = 4,
  parameter int          SLOT_W     = 3
)(
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata
);
  localparam int AW = $clog2(NUM_LDN) + SLOT_W;

  logic          idx_sel, dat_sel, port_rd;
  logic          unlocked, relock;
  logic [7:0]    index_q, ldn_q;
  logic          bank_hit;
  logic [AW-1:0] bank_addr;
  logic          ram_we, ram_re;
  logic [7:0]    ram_q;
  logic          rd_from_ram;
  logic [7:0]    rd_hold, rd_next;

  assign idx_sel = (bus_addr == INDEX_ADDR[ADDR_W-1:0]);
  assign dat_sel = (bus_addr == DATA_ADDR[ADDR_W-1:0]);
  assign port_rd = bus_rd && !bus_wr && (idx_sel || dat_sel);
  assign relock  = unlocked && bus_wr && dat_sel &&
                   index_q == IDX_CLOSE && bus_wdata == CLOSE_VAL;

  kcp_key_unlock u_key (
    .clk      (clk),
    .rst      (rst),
    .key_wr   (bus_wr && idx_sel),
    .key_byte (bus_wdata),
    .relock   (relock),
    .unlocked (unlocked)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      index_q <= 8'h00;
      ldn_q   <= 8'h00;
    end else if (unlocked && bus_wr) begin
      if (idx_sel) index_q <= bus_wdata;
      if (dat_sel && index_q == IDX_LDN) ldn_q <= bus_wdata;
    end
  end

  kcp_bank_decode #(.NUM_LDN(NUM_LDN), .SLOT_W(SLOT_W)) u_dec (
    .index    (index_q),
    .ldn      (ldn_q),
    .hit      (bank_hit),
    .ram_addr (bank_addr)
  );

  assign ram_we = unlocked && bus_wr && dat_sel && bank_hit;
  assign ram_re = unlocked && port_rd && dat_sel && bank_hit;

  kcp_bank_ram #(.AW(AW)) u_ram (
    .clk   (clk),
    .we    (ram_we),
    .re    (ram_re),
    .addr  (bank_addr),
    .wdata (bus_wdata),
    .rdata (ram_q)
  );

  always_comb begin
    if (!unlocked)    rd_next = 8'hFF;
    else if (idx_sel) rd_next = index_q;
    else begin
      case (index_q)
        IDX_LDN:   rd_next = ldn_q;
        IDX_ID_HI: rd_next = CHIP_ID[15:8];
        IDX_ID_LO: rd_next = CHIP_ID[7:0];
        IDX_REV:   rd_next = {4'h0, CHIP_REV};
        default:   rd_next = 8'h00;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_from_ram <= 1'b0;
      rd_hold     <= 8'hFF;
    end else if (port_rd) begin
      rd_from_ram <= ram_re;
      rd_hold     <= rd_next;
    end
  end

  assign bus_rdata = rd_from_ram ? ram_q : rd_hold;

  // R4: locked reads of either port give all ones
  p_locked_reads_ff_r4: assert property (@(posedge clk) disable iff (rst)
    (port_rd && !unlocked) |=> bus_rdata == 8'hFF);

  // R4: the selector cannot move while locked
  p_locked_ldn_stable_r4: assert property (@(posedge clk) disable iff (rst)
    !unlocked |=> $stable(ldn_q));

  // R5: the index changes only on an index-port write
  p_index_only_by_write_r5: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr && idx_sel) |=> $stable(index_q));

  // R6: identity high byte read
  p_id_high_r6: assert property (@(posedge clk) disable iff (rst)
    (port_rd && dat_sel && unlocked && index_q == IDX_ID_HI) |=> bus_rdata == CHIP_ID[15:8]);

  // R11: output holds between port reads
  p_rdata_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !port_rd |=> $stable(bus_rdata));
endmodule

// File: tb/kcp_cfg_port_bench.sv
module kcp_cfg_port_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] IDXP = 16'h002E;
  localparam logic [15:0] DATP = 16'h002F;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  kcp_cfg_port u_kcp_cfg_port (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic open_port();
    wr(IDXP, 8'h87); wr(IDXP, 8'h01); wr(IDXP, 8'h55); wr(IDXP, 8'h55);
  endtask

  task automatic close_port();
    wr(IDXP, 8'h02); wr(DATP, 8'h02);
  endtask

  task automatic reg_wr(input logic [7:0] idx, input logic [7:0] d);
    wr(IDXP, idx); wr(DATP, d);
  endtask

  task automatic reg_rd(input logic [7:0] idx, output logic [7:0] d);
    wr(IDXP, idx); rd(DATP, d);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    check("R1 rdata after reset", bus_rdata, 8'hFF);
    rd(DATP, v); check("R1 data port locked", v, 8'hFF);
    rd(IDXP, v); check("R4 index port locked", v, 8'hFF);
  endtask

  task automatic t_open_and_index();
    logic [7:0] v;
    open_port();
    rd(IDXP, v); check("R1 index zero after reset", v, 8'h00);
    reg_rd(8'h07, v); check("R1 selector zero after reset", v, 8'h00);
    wr(IDXP, 8'h5C); rd(IDXP, v); check("R5 index readback", v, 8'h5C);
  endtask

  task automatic t_ids();
    logic [7:0] v;
    reg_rd(8'h20, v); check("R6 id high", v, 8'h87);
    reg_rd(8'h21, v); check("R6 id low", v, 8'h12);
    reg_rd(8'h22, v); check("R6 revision", v, 8'h08);
    reg_wr(8'h20, 8'h3C); rd(DATP, v); check("R6 id write ignored", v, 8'h87);
  endtask

  task automatic t_banks();
    logic [7:0] v;
    for (int l = 0; l < 4; l++) begin
      reg_wr(8'h07, 8'(l));
      reg_wr(8'h30, 8'(8'h01 ^ l));
      reg_wr(8'h60, 8'(8'h10 + l));
      reg_wr(8'h61, 8'(8'h20 + l));
      reg_wr(8'h70, 8'(8'hA0 + l));
      reg_wr(8'h74, 8'(8'hB0 + l));
    end
    for (int l = 0; l < 4; l++) begin
      reg_wr(8'h07, 8'(l));
      reg_rd(8'h07, v); check("R7 selector readback", v, 8'(l));
      reg_rd(8'h30, v); check("R8 enable byte", v, 8'(8'h01 ^ l));
      reg_rd(8'h60, v); check("R8 base high", v, 8'(8'h10 + l));
      reg_rd(8'h61, v); check("R8 base low", v, 8'(8'h20 + l));
      reg_rd(8'h70, v); check("R8 first general", v, 8'(8'hA0 + l));
      reg_rd(8'h74, v); check("R7 last general per bank", v, 8'(8'hB0 + l));
    end
  endtask

  task automatic t_unimpl();
    logic [7:0] v;
    reg_wr(8'h07, 8'h00);
    reg_wr(8'h45, 8'h5A); rd(DATP, v); check("R9 unimplemented index", v, 8'h00);
    reg_wr(8'h75, 8'h6B); rd(DATP, v); check("R9 past general slots", v, 8'h00);
    reg_wr(8'h07, 8'h05);
    reg_wr(8'h30, 8'hEE); rd(DATP, v); check("R9 bank beyond range", v, 8'h00);
    reg_wr(8'h07, 8'h00);
    reg_rd(8'h30, v); check("R9 bank0 untouched", v, 8'h01);
  endtask

  task automatic t_hold();
    logic [7:0] v;
    reg_wr(8'h07, 8'h02);
    reg_rd(8'h60, v); check("R11 read value", v, 8'h12);
    repeat (3) @(negedge clk);
    check("R11 held while idle", bus_rdata, 8'h12);
    rd(16'h0080, v); check("R11 foreign read no effect", v, 8'h12);
    wr(IDXP, 8'h21);
    check("R11 held across index write", bus_rdata, 8'h12);
  endtask

  task automatic t_close();
    logic [7:0] v;
    reg_wr(8'h02, 8'h05);
    rd(IDXP, v); check("R10 other value stays open", v, 8'h02);
    wr(DATP, 8'h02);
    rd(IDXP, v); check("R10 close locks", v, 8'hFF);
  endtask

  task automatic t_locked_write();
    logic [7:0] v;
    open_port(); reg_wr(8'h07, 8'h01); reg_wr(8'h02, 8'h02);
    wr(DATP, 8'h03);
    open_port();
    wr(IDXP, 8'h07); rd(DATP, v); check("R4 locked write ignored", v, 8'h01);
    close_port();
  endtask

  task automatic t_key_restart();
    logic [7:0] v;
    wr(IDXP, 8'h87); wr(IDXP, 8'h01); wr(IDXP, 8'h33); wr(IDXP, 8'h55); wr(IDXP, 8'h55);
    rd(IDXP, v); check("R3 wrong byte restarts", v, 8'hFF);
    wr(IDXP, 8'h87); wr(IDXP, 8'h01); wr(IDXP, 8'h55);
    wr(IDXP, 8'h87); wr(IDXP, 8'h01); wr(IDXP, 8'h55); wr(IDXP, 8'h55);
    rd(IDXP, v); check("R3 restart on first key byte", v, 8'h02);
    close_port();
    wr(IDXP, 8'h87); wr(IDXP, 8'h87); wr(IDXP, 8'h01); wr(IDXP, 8'h55); wr(IDXP, 8'h55);
    rd(IDXP, v); check("R2 repeated first byte opens", v, 8'h02);
    close_port();
    wr(DATP, 8'h87); wr(DATP, 8'h01); wr(DATP, 8'h55); wr(DATP, 8'h55);
    rd(IDXP, v); check("R2 key on data port ignored", v, 8'hFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_open_and_index();
    t_ids();
    t_banks();
    t_unimpl();
    t_hold();
    t_close();
    t_locked_write();
    t_key_restart();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule